// File: doc/BRIEF.md
# Partitioned SIMD Carry Adder

A 16-bit combinational adder whose carry path can be cut at any bit boundary at run time. A vector of split enables, indexed by bit position, marks where a new lane begins. A mask stage turns the enables into a carry-pass mask. The ripple chain then discards any carry that reaches a bit whose mask bit is clear. One adder can therefore serve as a single 16-bit add, as two 8-bit adds, as sixteen 1-bit adds, or as any uneven mix of lane widths, and every lane works on its own.

The result packs the per-lane sums in place. Each lane keeps its own bit positions, and each lane sum is reduced modulo two to the power of that lane's width. No carry-out is produced for any lane. The carry-pass mask is also driven out so that the lane layout can be observed. The block has no clock, so both outputs follow the inputs within the same cycle. There is no stream handshake, because no data is held in the block.

Top module: `part_simd_adder`

## Requirements
- R1: Bit i of `carry_mask_o` is 0 exactly when `split_pts[i]` is 1, and is 1 otherwise. For example, an enable only at bit 1 gives 0xFFFD, and adding an enable at bit 10 gives 0xFBFD.
- R2: When `split_pts[15:1]` is all zero, `sum_o` equals (`opnd_a` + `opnd_b`) mod 2^16.
- R3: A lane is a maximal run of bits from bit j up to the next set enable above j, where bit j is either bit 0 or a bit whose enable is set. Over each lane with mask m, `sum_o & m` equals ((`opnd_a` & m) + (`opnd_b` & m)) & m.
- R4: No carry enters a bit whose enable is set: at every such bit i, `sum_o[i]` equals `opnd_a[i]` XOR `opnd_b[i]`.
- R5: `split_pts[0]` has no effect on `sum_o`.
- R6: Any subset of enables may be active at once. With every enable from bit 1 to bit 15 set, `sum_o` equals `opnd_a` XOR `opnd_b`.
- R7: Operand pairs built only from 0x0000 and 0xFFFF give the lane-wise result of R3 under every enable pattern.
- R8: Both outputs are purely combinational and reflect new inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First addend |
| opnd_b | input | 16 | Second addend |
| split_pts | input | 16 | Lane-start enables; bit i starts a new lane at bit i |
| sum_o | output | 16 | Packed per-lane sums |
| carry_mask_o | output | 16 | Carry-pass mask; a 0 marks a lane start |

## Verification
The assertions are immediate checks that are evaluated whenever the combinational logic settles. They assume that every input bit holds a known 0 or 1 and that the inputs stay unchanged while the outputs are being evaluated. The stimulus drives only fully known values. It holds each vector for a fixed delay before the outputs are sampled, and it never changes an input at the moment of sampling. Bit 0 of the enables is allowed to take either value, because it must not affect the sum.

// File: rtl/part_add_pkg.sv
package part_add_pkg;
  localparam int unsigned PA_WIDTH = 16;
  localparam int unsigned PA_LAST  = PA_WIDTH - 1;
endpackage

// File: rtl/part_mask_gen.sv
module part_mask_gen #(
  parameter int unsigned WIDTH = part_add_pkg::PA_WIDTH
) (
  input  logic [WIDTH-1:0] split_pts,
  output logic [WIDTH-1:0] carry_mask
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry_mask[i] = ~split_pts[i];
  end

  always_comb begin
    // R1
    mask_count_chk: assert ($countones(~carry_mask) == $countones(split_pts))
      else $error("mask zero count differs from enable count");
  end
endmodule

// File: rtl/part_bit_cell.sv
module part_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic carry_in,
  input  logic pass_en,
  output logic sum_bit,
  output logic carry_out,
  output logic carry_used
);
  logic cin_gated;
  assign cin_gated  = carry_in & pass_en;
  assign carry_used = cin_gated;
  assign sum_bit    = a_i ^ b_i ^ cin_gated;
  assign carry_out  = (a_i & b_i) | (cin_gated & (a_i ^ b_i));
endmodule

// File: rtl/part_carry_chain.sv
module part_carry_chain #(
  parameter int unsigned WIDTH = part_add_pkg::PA_WIDTH
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic [WIDTH-1:0] carry_mask,
  output logic [WIDTH-1:0] sum_vec,
  output logic [WIDTH-1:0] carry_taken
);
  logic [WIDTH:0] ripple;
  assign ripple[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    part_bit_cell u_cell (
      .a_i        (a_vec[i]),
      .b_i        (b_vec[i]),
      .carry_in   (ripple[i]),
      .pass_en    (carry_mask[i]),
      .sum_bit    (sum_vec[i]),
      .carry_out  (ripple[i+1]),
      .carry_used (carry_taken[i])
    );
  end

  always_comb begin
    // R4
    carry_kill_chk: assert ((carry_taken & ~carry_mask) == '0)
      else $error("carry accepted at a lane start");
  end
endmodule

// File: rtl/part_simd_adder.sv
module part_simd_adder #(
  parameter int unsigned WIDTH = part_add_pkg::PA_WIDTH
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] split_pts,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_mask_o
);
  localparam int unsigned UPPER = WIDTH - 1;

  logic [WIDTH-1:0] mask_w;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] taken_w;

  part_mask_gen #(.WIDTH(WIDTH)) u_mask (
    .split_pts  (split_pts),
    .carry_mask (mask_w)
  );

  part_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .a_vec       (opnd_a),
    .b_vec       (opnd_b),
    .carry_mask  (mask_w),
    .sum_vec     (sum_w),
    .carry_taken (taken_w)
  );

  assign sum_o        = sum_w;
  assign carry_mask_o = mask_w;

  always_comb begin
    // R4
    lane_start_xor_chk: assert (((sum_o ^ opnd_a ^ opnd_b) & split_pts & ~WIDTH'(1)) == '0)
      else $error("carry leaked into a lane start");
    // R2
    if (split_pts[UPPER:1] == '0) begin
      full_add_chk: assert (sum_o == WIDTH'(opnd_a + opnd_b))
        else $error("unsplit sum wrong");
    end
    // R6
    if (&split_pts[UPPER:1]) begin
      all_split_chk: assert (sum_o == (opnd_a ^ opnd_b))
        else $error("bitwise lanes wrong");
    end
  end
endmodule

// File: tb/part_simd_adder_tb.sv
module part_simd_adder_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic [W-1:0] a, b, pts, sum, mask;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  part_simd_adder u_dut (
    .opnd_a(a), .opnd_b(b), .split_pts(pts),
    .sum_o(sum), .carry_mask_o(mask)
  );

  function automatic logic [W-1:0] lane_ref(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic [W-1:0] p);
    logic [W-1:0] res = '0;
    int lo = 0;
    for (int i = 1; i <= W; i++) begin
      if (i == W || p[i]) begin
        logic [W:0] m = '0;
        logic [W:0] s;
        for (int k = lo; k < i; k++) m[k] = 1'b1;
        s = ({1'b0, x} & m) + ({1'b0, y} & m);
        res = res | W'(s & m);
        lo = i;
      end
    end
    return res;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h a=%h b=%h pts=%h", tag, act, exp, a, b, pts);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [W-1:0] p,
                       input string tag);
    logic [W-1:0] e;
    a = x; b = y; pts = p;
    #1;
    e = lane_ref(x, y, p);
    chk(sum === e, tag, sum, e);
    chk(mask === ~p, "R1 mask", mask, ~p);
    #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] corners [4];
    corners[0] = 16'h0000; corners[1] = 16'hFFFF;
    corners[2] = 16'hFFFF; corners[3] = 16'h0000;
    a = '0; b = '0; pts = '0;
    #1;
    chk(sum === 16'h0000, "R8 idle sum", sum, 16'h0000);
    chk(mask === 16'hFFFF, "R1 idle mask", mask, 16'hFFFF);
    pts = 16'h0002; #1;
    chk(mask === 16'hFFFD, "R1 bit1", mask, 16'hFFFD);
    pts = 16'h0402; #1;
    chk(mask === 16'hFBFD, "R1 bit1+10", mask, 16'hFBFD);
    // R8: new inputs seen without a clock edge
    a = 16'h00FF; b = 16'h0001; pts = 16'h0000; #1;
    chk(sum === 16'h0100, "R8 settle", sum, 16'h0100);
    pts = 16'h0100; #1;
    chk(sum === 16'h0000, "R4 byte split", sum, 16'h0000);
    // R2 plain adder with carry discarded
    apply(16'hFFFF, 16'h0001, 16'h0000, "R2 wrap");
    apply(16'h1234, 16'hEDCC, 16'h0001, "R2 bit0 only");
    // R6 all lanes width 1
    apply(16'hA5F0, 16'h0FF0, 16'hFFFE, "R6 all split");
    // R7 corner pairs on every pattern, R3 random on every pattern, R5 bit0 toggle
    for (int p = 0; p < 32768; p++) begin
      logic [W-1:0] pv = {p[14:0], 1'b0};
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      apply(corners[p % 4], corners[(p / 4) % 4 == 0 ? 1 : (p % 4 == 1 ? 2 : 3)], pv, "R7 corners");
      if (p % 2 == 0) apply(ra, rb, pv, "R3 lanes");
      else            apply(ra, rb, pv | 16'h0001, "R5 bit0 ignored");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule